// File: doc/BRIEF.md
# Shared Processing-Element Pool Allocator

This block schedules vector jobs for a multiple-SIMD machine in which a few control units draw their processing elements from one shared pool. Each job arrives on a valid/ready input with a tag and the number of elements it needs. That number stays fixed while the job is in service. Accepted jobs wait in a small queue. Whenever a control unit is idle and a waiting job fits in the free element count, the block grants that job to the unit and subtracts its demand from the pool. A completion pulse from the unit returns the elements.

Two waiting-queue disciplines are available, chosen by a policy input. In arrival-order mode only the oldest job may be granted, so a large job at the head blocks smaller ones behind it. In least-demand mode the smallest job that fits is taken, and the older job wins a tie. Jobs can finish out of order, so a resequencing buffer holds the early finishers. Retire pulses then leave strictly in arrival order, one job per pulse.

Top module: `pe_pool_sched`

## Requirements
- R1: After reset, `job_ready_o` is 1 and `grant_o`, `retire_valid_o` and `job_reject_o` are all 0.
- R2: A job that is accepted with demand 0, or with demand greater than POOL_SIZE (default 128), produces a one-cycle `job_reject_o` pulse on the next cycle. It is never queued, granted or retired. A demand equal to POOL_SIZE is legal.
- R3: With `policy_i` = 0 (arrival order), jobs are granted in arrival order. If the oldest waiting job needs more elements than are free, nothing is granted, even when a later job would fit.
- R4: With `policy_i` = 1 (least demand), the granted job is the waiting job with the smallest demand among those that fit the free count. A tie goes to the older job.
- R5: A control unit holds at most one job. A grant goes to the lowest-numbered idle unit, at most one grant is issued per cycle, and no job is granted while every unit is busy.
- R6: The sum of the demands of granted, unfinished jobs never exceeds POOL_SIZE. A completion returns its elements in the cycle it is sampled. If a grant and a completion fall in the same cycle, both updates apply.
- R7: Each accepted job produces exactly one `retire_valid_o` pulse carrying its tag. Pulses come in arrival order, whatever the completion order. Consecutive ready jobs retire on consecutive cycles.
- R8: `job_ready_o` is 0 while the waiting queue holds QUEUE_DEPTH jobs, or while ROB_DEPTH accepted jobs have not yet retired. A job offered while ready is 0 is not taken.
- R9: A `done_i` pulse to a control unit that holds no job has no effect on the pool or on retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| policy_i | input | 1 | Queue discipline: 0 arrival order, 1 least demand first |
| job_valid_i | input | 1 | A job is offered |
| job_ready_o | output | 1 | The block can take a job |
| job_tag_i | input | TAG_W | Tag of the offered job |
| job_dem_i | input | CNT_W | Element demand of the offered job |
| job_reject_o | output | 1 | Pulse: the last accepted job had an illegal demand |
| grant_o | output | NUM_CU | Pulse per unit: a job was granted to it |
| grant_tag_o | output | NUM_CU*TAG_W | Tag of the job held by each unit (unit c at bits c*TAG_W) |
| grant_dem_o | output | NUM_CU*CNT_W | Demand of the job held by each unit |
| done_i | input | NUM_CU | Pulse per unit: its job completed |
| retire_valid_o | output | 1 | A job leaves in arrival order |
| retire_tag_o | output | TAG_W | Tag of the retiring job |

## Verification
A job accepted at a clock edge can be granted at the next edge at the earliest, so its `grant_o` pulse is visible one cycle after acceptance. The reject pulse is visible in the cycle that follows the accepting edge. A completion sampled at an edge frees its elements at that edge, so a blocked job is granted one edge later. The retire pulse of the oldest job is visible in the cycle right after its completion edge. The bench drives inputs on falling edges and logs every output pulse on falling edges together with a cycle count. It then compares the logged cycle against the acceptance or completion cycle plus these fixed latencies.

// File: rtl/pe_pool_pkg.sv
// Shared definitions for the processing-element pool allocator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package pe_pool_pkg;

    // Waiting-queue discipline selected at the block's policy input.
    typedef enum logic {
        POL_ARRIVAL = 1'b0,
        POL_LEAST   = 1'b1
    } pool_policy_e;

    // Index width for a structure of n entries, never below one bit.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pe_wait_queue.sv
// Age-ordered waiting queue with a grant picker.
// Entry 0 is always the oldest job; entries [0, occ) are live.
// Picks the head (arrival order) or the smallest fitting demand
// (least demand, older wins a tie). The picked entry is removed on pop.
// Assumes the caller never pushes while full and pops only a valid pick.
module pe_wait_queue
    import pe_pool_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TAG_W = 8,
    parameter int CNT_W = 8,
    parameter int SEQ_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pool_policy_e     policy,
    input  logic [CNT_W-1:0] free_cnt,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    input  logic [CNT_W-1:0] push_dem,
    input  logic [SEQ_W-1:0] push_seq,
    input  logic             pop,
    output logic             full,
    output logic             pick_valid,
    output logic [TAG_W-1:0] pick_tag,
    output logic [CNT_W-1:0] pick_dem,
    output logic [SEQ_W-1:0] pick_seq
);
    localparam int IDX_W = idx_bits(DEPTH);
    localparam int OCC_W = $clog2(DEPTH + 1);

    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [TAG_W-1:0] tag_d [DEPTH];
    logic [CNT_W-1:0] dem_q [DEPTH];
    logic [CNT_W-1:0] dem_d [DEPTH];
    logic [SEQ_W-1:0] seq_q [DEPTH];
    logic [SEQ_W-1:0] seq_d [DEPTH];
    logic [OCC_W-1:0] occ_q, occ_d, occ_mid;
    logic [IDX_W-1:0] pick_idx;

    assign full = (occ_q == OCC_W'(DEPTH));

    // Choose the entry to grant under the current policy and free count.
    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        if (policy == POL_ARRIVAL) begin
            if (occ_q != '0 && dem_q[0] <= free_cnt) pick_valid = 1'b1;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (OCC_W'(i) < occ_q && dem_q[i] <= free_cnt &&
                    (!pick_valid || dem_q[i] < dem_q[pick_idx])) begin
                    pick_valid = 1'b1;
                    pick_idx   = IDX_W'(i);
                end
            end
        end
    end

    assign pick_tag = tag_q[pick_idx];
    assign pick_dem = dem_q[pick_idx];
    assign pick_seq = seq_q[pick_idx];

    // Remove the picked entry by shifting younger ones down, then append.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            tag_d[i] = tag_q[i];
            dem_d[i] = dem_q[i];
            seq_d[i] = seq_q[i];
        end
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IDX_W'(i) >= pick_idx) begin
                    tag_d[i] = tag_q[i+1];
                    dem_d[i] = dem_q[i+1];
                    seq_d[i] = seq_q[i+1];
                end
            end
        end
        occ_mid = occ_q - OCC_W'(pop);
        if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (OCC_W'(i) == occ_mid) begin
                    tag_d[i] = push_tag;
                    dem_d[i] = push_dem;
                    seq_d[i] = push_seq;
                end
            end
        end
        occ_d = occ_mid + OCC_W'(push);
    end

    // Occupancy register.
    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_d;
    end

    // Entry payload storage; liveness is carried by occupancy alone.
    always_ff @(posedge clk) begin
        tag_q <= tag_d;
        dem_q <= dem_d;
        seq_q <= seq_d;
    end

    assert_push_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_head_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && policy == POL_ARRIVAL) |-> pick_idx == '0);
    assert_pick_fits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (pick_valid && pick_dem <= free_cnt));
    assert_occ_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OCC_W'(DEPTH));

endmodule

// File: rtl/pe_cu_bank.sv
// Control-unit occupancy and the free element counter.
// Each unit holds one job from its grant edge until its done pulse.
// A grant goes to the lowest-numbered idle unit; a done pulse to an
// idle unit is ignored. Grant and release update the pool in one edge.
// Assumes take is raised only when any_idle is high and the demand fits.
module pe_cu_bank
    import pe_pool_pkg::*;
#(
    parameter int NUM_CU    = 2,
    parameter int POOL_SIZE = 128,
    parameter int TAG_W     = 8,
    parameter int CNT_W     = 8,
    parameter int SEQ_W     = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    input  logic [TAG_W-1:0]        take_tag,
    input  logic [CNT_W-1:0]        take_dem,
    input  logic [SEQ_W-1:0]        take_seq,
    input  logic [NUM_CU-1:0]       done_i,
    output logic                    any_idle,
    output logic [CNT_W-1:0]        free_cnt,
    output logic [NUM_CU-1:0]       grant_o,
    output logic [NUM_CU*TAG_W-1:0] grant_tag_o,
    output logic [NUM_CU*CNT_W-1:0] grant_dem_o,
    output logic [NUM_CU-1:0]       fin_o,
    output logic [NUM_CU*SEQ_W-1:0] fin_seq_o
);
    localparam int SUM_W = CNT_W + 1;

    logic [NUM_CU-1:0] busy_q;
    logic [NUM_CU-1:0] sel;
    logic [TAG_W-1:0]  tag_q [NUM_CU];
    logic [CNT_W-1:0]  dem_q [NUM_CU];
    logic [SEQ_W-1:0]  seq_q [NUM_CU];
    logic [CNT_W-1:0]  free_q;
    logic [SUM_W-1:0]  rel_sum, held_sum, free_nxt;

    assign any_idle = ~&busy_q;
    assign fin_o    = done_i & busy_q;
    assign free_cnt = free_q;

    // One-hot select of the lowest-numbered idle unit.
    always_comb begin
        sel = '0;
        for (int c = 0; c < NUM_CU; c++) begin
            if (!busy_q[c] && sel == '0) sel[c] = 1'b1;
        end
    end

    // Elements returned this cycle and elements currently held.
    always_comb begin
        rel_sum  = '0;
        held_sum = '0;
        for (int c = 0; c < NUM_CU; c++) begin
            if (fin_o[c])  rel_sum  = rel_sum + SUM_W'(dem_q[c]);
            if (busy_q[c]) held_sum = held_sum + SUM_W'(dem_q[c]);
        end
        free_nxt = SUM_W'(free_q) + rel_sum - (take ? SUM_W'(take_dem) : '0);
    end

    // Free element counter: both grant and release apply in one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= CNT_W'(POOL_SIZE);
        else        free_q <= free_nxt[CNT_W-1:0];
    end

    // Unit occupancy and one-cycle grant pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= '0;
            grant_o <= '0;
        end else begin
            for (int c = 0; c < NUM_CU; c++) begin
                grant_o[c] <= take && sel[c];
                if (take && sel[c])  busy_q[c] <= 1'b1;
                else if (fin_o[c])   busy_q[c] <= 1'b0;
            end
        end
    end

    // Job payload held by each unit, loaded at its grant edge.
    always_ff @(posedge clk) begin
        for (int c = 0; c < NUM_CU; c++) begin
            if (take && sel[c]) begin
                tag_q[c] <= take_tag;
                dem_q[c] <= take_dem;
                seq_q[c] <= take_seq;
            end
        end
    end

    for (genvar c = 0; c < NUM_CU; c++) begin : g_unit
        assign grant_tag_o[c*TAG_W +: TAG_W] = tag_q[c];
        assign grant_dem_o[c*CNT_W +: CNT_W] = dem_q[c];
        assign fin_seq_o[c*SEQ_W +: SEQ_W]   = seq_q[c];

        assert_grant_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
            grant_o[c] |-> !$past(busy_q[c]));
    end

    assert_one_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));
    assert_take_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> any_idle);
    assert_free_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        free_q <= CNT_W'(POOL_SIZE));
    assert_pool_conserve_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (SUM_W'(free_q) + held_sum) == SUM_W'(POOL_SIZE));

endmodule

// File: rtl/pe_reorder_buf.sv
// Resequencing buffer restoring arrival order at the output.
// Every accepted job takes the slot at the tail; its slot index is its
// sequence number. Completions mark slots done; the head slot retires
// when done, one per cycle, as a combinational pulse from state.
// Assumes DEPTH is a power of two and no alloc while full.
module pe_reorder_buf #(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 8,
    parameter int NUM_CU = 2,
    parameter int SEQ_W  = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc,
    input  logic [TAG_W-1:0]        alloc_tag,
    output logic [SEQ_W-1:0]        alloc_seq,
    output logic                    full,
    input  logic [NUM_CU-1:0]       fin_i,
    input  logic [NUM_CU*SEQ_W-1:0] fin_seq_i,
    output logic                    retire_valid,
    output logic [TAG_W-1:0]        retire_tag
);
    localparam int OCC_W = $clog2(DEPTH + 1);

    logic [SEQ_W-1:0] head_q, tail_q;
    logic [OCC_W-1:0] occ_q;
    logic [DEPTH-1:0] done_q, done_d;
    logic [TAG_W-1:0] tag_q [DEPTH];

    assign alloc_seq    = tail_q;
    assign full         = (occ_q == OCC_W'(DEPTH));
    assign retire_valid = done_q[head_q];
    assign retire_tag   = tag_q[head_q];

    // Next done flags: mark finished slots, clear the retiring head.
    always_comb begin
        done_d = done_q;
        for (int c = 0; c < NUM_CU; c++) begin
            if (fin_i[c]) done_d[fin_seq_i[c*SEQ_W +: SEQ_W]] = 1'b1;
        end
        if (retire_valid) done_d[head_q] = 1'b0;
    end

    // Pointers, occupancy and done flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
            done_q <= '0;
        end else begin
            done_q <= done_d;
            if (alloc)        tail_q <= tail_q + 1'b1;
            if (retire_valid) head_q <= head_q + 1'b1;
            occ_q <= occ_q + OCC_W'(alloc) - OCC_W'(retire_valid);
        end
    end

    // Tag storage written at allocation.
    always_ff @(posedge clk) begin
        if (alloc) tag_q[tail_q] <= alloc_tag;
    end

    for (genvar c = 0; c < NUM_CU; c++) begin : g_mark
        assert_mark_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
            fin_i[c] |-> !done_q[fin_seq_i[c*SEQ_W +: SEQ_W]]);
    end

    assert_retire_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |-> occ_q != '0);
    assert_alloc_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !full);

endmodule

// File: rtl/pe_pool_sched.sv
// Top of the shared processing-element pool allocator.
// Validates incoming jobs, queues legal ones, grants them to idle
// control units under the selected policy and retires them in arrival
// order. Assumes done_i is a one-cycle pulse per completed job.
module pe_pool_sched
    import pe_pool_pkg::*;
#(
    parameter int NUM_CU      = 2,
    parameter int POOL_SIZE   = 128,
    parameter int QUEUE_DEPTH = 4,
    parameter int ROB_DEPTH   = 8,
    parameter int TAG_W       = 8,
    localparam int CNT_W      = $clog2(POOL_SIZE + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    policy_i,
    input  logic                    job_valid_i,
    output logic                    job_ready_o,
    input  logic [TAG_W-1:0]        job_tag_i,
    input  logic [CNT_W-1:0]        job_dem_i,
    output logic                    job_reject_o,
    output logic [NUM_CU-1:0]       grant_o,
    output logic [NUM_CU*TAG_W-1:0] grant_tag_o,
    output logic [NUM_CU*CNT_W-1:0] grant_dem_o,
    input  logic [NUM_CU-1:0]       done_i,
    output logic                    retire_valid_o,
    output logic [TAG_W-1:0]        retire_tag_o
);
    localparam int SEQ_W = $clog2(ROB_DEPTH);

    logic                    q_full, rob_full, accept, illegal, push;
    logic                    pick_valid, any_idle, take;
    logic [TAG_W-1:0]        pick_tag;
    logic [CNT_W-1:0]        pick_dem, free_cnt;
    logic [SEQ_W-1:0]        pick_seq, new_seq;
    logic [NUM_CU-1:0]       fin;
    logic [NUM_CU*SEQ_W-1:0] fin_seq;

    assign job_ready_o = !q_full && !rob_full;
    assign accept      = job_valid_i && job_ready_o;
    assign illegal     = (job_dem_i == '0) || (job_dem_i > CNT_W'(POOL_SIZE));
    assign push        = accept && !illegal;
    assign take        = pick_valid && any_idle;

    // Registered reject pulse for an accepted job with an illegal demand.
    always_ff @(posedge clk) begin
        if (!rst_n) job_reject_o <= 1'b0;
        else        job_reject_o <= accept && illegal;
    end

    pe_wait_queue #(
        .DEPTH (QUEUE_DEPTH),
        .TAG_W (TAG_W),
        .CNT_W (CNT_W),
        .SEQ_W (SEQ_W)
    ) wait_q_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .policy     (pool_policy_e'(policy_i)),
        .free_cnt   (free_cnt),
        .push       (push),
        .push_tag   (job_tag_i),
        .push_dem   (job_dem_i),
        .push_seq   (new_seq),
        .pop        (take),
        .full       (q_full),
        .pick_valid (pick_valid),
        .pick_tag   (pick_tag),
        .pick_dem   (pick_dem),
        .pick_seq   (pick_seq)
    );

    pe_cu_bank #(
        .NUM_CU    (NUM_CU),
        .POOL_SIZE (POOL_SIZE),
        .TAG_W     (TAG_W),
        .CNT_W     (CNT_W),
        .SEQ_W     (SEQ_W)
    ) cu_bank_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (take),
        .take_tag    (pick_tag),
        .take_dem    (pick_dem),
        .take_seq    (pick_seq),
        .done_i      (done_i),
        .any_idle    (any_idle),
        .free_cnt    (free_cnt),
        .grant_o     (grant_o),
        .grant_tag_o (grant_tag_o),
        .grant_dem_o (grant_dem_o),
        .fin_o       (fin),
        .fin_seq_o   (fin_seq)
    );

    pe_reorder_buf #(
        .DEPTH  (ROB_DEPTH),
        .TAG_W  (TAG_W),
        .NUM_CU (NUM_CU),
        .SEQ_W  (SEQ_W)
    ) rob_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc        (push),
        .alloc_tag    (job_tag_i),
        .alloc_seq    (new_seq),
        .full         (rob_full),
        .fin_i        (fin),
        .fin_seq_i    (fin_seq),
        .retire_valid (retire_valid_o),
        .retire_tag   (retire_tag_o)
    );

    assert_reject_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        job_reject_o |-> !$past(push));

endmodule

// File: tb/pe_pool_sched_tb.sv
// Directed bench for the pool allocator: one task per scenario.
module pe_pool_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CU     = 2;
    localparam int POOL       = 128;
    localparam int TAG_W      = 8;
    localparam int CNT_W      = 8;
    localparam int LOG_N      = 64;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    policy = 1'b0;
    logic                    job_valid = 1'b0;
    logic                    job_ready;
    logic [TAG_W-1:0]        job_tag = '0;
    logic [CNT_W-1:0]        job_dem = '0;
    logic                    job_reject;
    logic [NUM_CU-1:0]       grant;
    logic [NUM_CU*TAG_W-1:0] grant_tag;
    logic [NUM_CU*CNT_W-1:0] grant_dem;
    logic [NUM_CU-1:0]       done = '0;
    logic                    retire_valid;
    logic [TAG_W-1:0]        retire_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    pe_pool_sched dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .policy_i       (policy),
        .job_valid_i    (job_valid),
        .job_ready_o    (job_ready),
        .job_tag_i      (job_tag),
        .job_dem_i      (job_dem),
        .job_reject_o   (job_reject),
        .grant_o        (grant),
        .grant_tag_o    (grant_tag),
        .grant_dem_o    (grant_dem),
        .done_i         (done),
        .retire_valid_o (retire_valid),
        .retire_tag_o   (retire_tag)
    );

    int cyc = 0;
    int total = 0;
    int bad = 0;
    int last_cyc = 0;
    bit finished = 1'b0;

    int g_n, r_n, rej_n, rej_cyc;
    int g_tag [LOG_N];
    int g_cu  [LOG_N];
    int g_cyc [LOG_N];
    int r_tag [LOG_N];
    int r_cyc [LOG_N];

    always @(posedge clk) cyc = cyc + 1;

    // Log output pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NUM_CU; c++) begin
                if (grant[c] && g_n < LOG_N) begin
                    g_tag[g_n] = int'(grant_tag[c*TAG_W +: TAG_W]);
                    g_cu[g_n]  = c;
                    g_cyc[g_n] = cyc;
                    g_n++;
                end
            end
            if (retire_valid && r_n < LOG_N) begin
                r_tag[r_n] = int'(retire_tag);
                r_cyc[r_n] = cyc;
                r_n++;
            end
            if (job_reject) begin
                rej_n++;
                rej_cyc = cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_g(input int i, input int tag, input int cu, input string req);
        int at, ac;
        at = (i < g_n) ? g_tag[i] : -1;
        ac = (i < g_n) ? g_cu[i] : -1;
        chk(at == tag, req, $sformatf("grant %0d tag", i), at, tag);
        chk(ac == cu, req, $sformatf("grant %0d unit", i), ac, cu);
    endtask

    task automatic chk_r(input int i, input int tag, input string req);
        int at;
        at = (i < r_n) ? r_tag[i] : -1;
        chk(at == tag, req, $sformatf("retire %0d tag", i), at, tag);
    endtask

    task automatic do_reset(input bit ldf);
        @(negedge clk);
        rst_n = 1'b0;
        job_valid = 1'b0;
        done = '0;
        policy = ldf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        g_n = 0;
        r_n = 0;
        rej_n = 0;
        rej_cyc = -1;
    endtask

    // Entered at a falling edge; offers one job across one rising edge.
    task automatic push(input int tag, input int dem);
        job_valid = 1'b1;
        job_tag = TAG_W'(tag);
        job_dem = CNT_W'(dem);
        @(posedge clk);
        #1 last_cyc = cyc;
        @(negedge clk);
        job_valid = 1'b0;
    endtask

    task automatic finish(input int cu);
        done[cu] = 1'b1;
        @(posedge clk);
        #1 last_cyc = cyc;
        @(negedge clk);
        done = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk(job_ready == 1'b1, "R1", "ready after reset", int'(job_ready), 1);
        chk(grant == '0, "R1", "grant after reset", int'(grant), 0);
        chk(retire_valid == 1'b0, "R1", "retire after reset", int'(retire_valid), 0);
        chk(job_reject == 1'b0, "R1", "reject after reset", int'(job_reject), 0);
    endtask

    task automatic t_reject();
        int acc;
        do_reset(1'b0);
        push(1, 0);
        acc = last_cyc;
        idle(1);
        chk(rej_cyc == acc, "R2", "reject pulse cycle", rej_cyc, acc);
        push(2, 129);
        idle(3);
        chk(rej_n == 2, "R2", "reject count", rej_n, 2);
        chk(g_n == 0, "R2", "rejected jobs not granted", g_n, 0);
        push(3, 128);
        acc = last_cyc;
        idle(2);
        chk_g(0, 3, 0, "R2");
        chk(g_cyc[0] == acc + 1, "R2", "full-pool grant cycle", g_cyc[0], acc + 1);
        finish(0);
        idle(3);
        chk(r_n == 1, "R2", "only legal job retires", r_n, 1);
        chk_r(0, 3, "R2");
    endtask

    task automatic t_arrival_hol();
        int fc;
        do_reset(1'b0);
        push(10, 100);
        push(11, 50);
        push(12, 10);
        idle(4);
        chk(g_n == 1, "R3", "head blocks smaller job", g_n, 1);
        finish(0);
        fc = last_cyc;
        idle(3);
        chk_g(0, 10, 0, "R3");
        chk_g(1, 11, 0, "R3");
        chk_g(2, 12, 1, "R3");
        chk(g_cyc[1] == fc + 1, "R6", "grant one edge after release", g_cyc[1], fc + 1);
        finish(0);
        finish(1);
        idle(3);
        chk(r_n == 3, "R7", "retire count", r_n, 3);
        chk_r(0, 10, "R7");
        chk_r(1, 11, "R7");
        chk_r(2, 12, "R7");
    endtask

    task automatic t_least();
        do_reset(1'b1);
        push(20, 120);
        push(21, 50);
        push(22, 30);
        push(23, 30);
        push(24, 5);
        idle(2);
        chk(g_n == 2, "R4", "only fitting job granted", g_n, 2);
        chk_g(1, 24, 1, "R4");
        finish(1);
        idle(3);
        chk(g_n == 2, "R4", "no fit after small release", g_n, 2);
        finish(0);
        idle(3);
        chk_g(2, 22, 0, "R4");
        chk_g(3, 23, 1, "R4");
        chk(g_n == 4, "R5", "no grant with all units busy", g_n, 4);
        finish(0);
        idle(2);
        chk_g(4, 21, 0, "R4");
        finish(1);
        finish(0);
        idle(4);
        chk(r_n == 5, "R7", "retire count", r_n, 5);
        for (int i = 0; i < 5; i++) chk_r(i, 20 + i, "R7");
    endtask

    task automatic t_same_cycle();
        int fc;
        do_reset(1'b1);
        push(30, 60);
        push(31, 68);
        finish(0);
        fc = last_cyc;
        idle(2);
        chk_g(1, 31, 1, "R6");
        chk(g_cyc[1] == fc, "R6", "grant on release edge", g_cyc[1], fc);
        push(32, 61);
        push(33, 60);
        idle(3);
        chk(g_n == 3, "R6", "pool holds exactly 60", g_n, 3);
        chk_g(2, 33, 0, "R6");
        finish(1);
        idle(2);
        chk_g(3, 32, 1, "R6");
        finish(0);
        finish(1);
        idle(3);
        chk(r_n == 4, "R7", "retire count", r_n, 4);
        for (int i = 0; i < 4; i++) chk_r(i, 30 + i, "R7");
    endtask

    task automatic t_units();
        do_reset(1'b0);
        finish(0);
        push(40, 10);
        push(41, 10);
        push(42, 10);
        idle(3);
        chk(g_n == 2, "R5", "one job per unit", g_n, 2);
        chk_g(0, 40, 0, "R5");
        chk_g(1, 41, 1, "R5");
        finish(0);
        idle(2);
        chk_g(2, 42, 0, "R5");
        finish(1);
        finish(0);
        idle(3);
        chk(r_n == 3, "R7", "retire count", r_n, 3);
        finish(1);
        finish(0);
        idle(3);
        chk(r_n == 3, "R9", "idle done adds no retire", r_n, 3);
        push(43, 100);
        push(44, 38);
        idle(3);
        chk(g_n == 4, "R9", "idle done frees nothing", g_n, 4);
        finish(0);
        idle(2);
        chk_g(4, 44, 0, "R9");
        finish(0);
        idle(3);
        chk(r_n == 5, "R9", "retire count", r_n, 5);
    endtask

    task automatic t_ready();
        int fc;
        do_reset(1'b0);
        push(50, 100);
        push(51, 28);
        for (int k = 0; k < 4; k++) push(52 + k, 1);
        chk(job_ready == 1'b0, "R8", "ready low with queue full", int'(job_ready), 0);
        push(56, 1);
        for (int k = 0; k < 3; k++) begin
            finish(k % 2);
            idle(2);
        end
        finish(1);
        idle(2);
        finish(0);
        finish(1);
        idle(3);
        chk(g_n == 6, "R8", "refused job never granted", g_n, 6);
        chk(r_n == 6, "R8", "refused job never retired", r_n, 6);
        chk_r(5, 55, "R8");
        chk(job_ready == 1'b1, "R8", "ready restored", int'(job_ready), 1);

        do_reset(1'b0);
        push(60, 1);
        for (int k = 0; k < 7; k++) begin
            push(61 + k, 1);
            idle(1);
            finish(1);
        end
        chk(job_ready == 1'b0, "R8", "ready low with buffer full", int'(job_ready), 0);
        chk(r_n == 0, "R7", "early finishers held", r_n, 0);
        finish(0);
        fc = last_cyc;
        idle(10);
        chk(r_n == 8, "R7", "retire count", r_n, 8);
        for (int i = 0; i < 8; i++) chk_r(i, 60 + i, "R7");
        chk(r_cyc[0] == fc, "R7", "first retire cycle", r_cyc[0], fc);
        chk(r_cyc[7] == fc + 7, "R7", "back-to-back retire", r_cyc[7], fc + 7);
        chk(job_ready == 1'b1, "R8", "ready after drain", int'(job_ready), 1);
    endtask

    initial begin
        t_reset();
        t_reject();
        t_arrival_hol();
        t_least();
        t_same_cycle();
        t_units();
        t_ready();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule